// File: doc/BRIEF.md
# Barrel-Threaded Multi-Context Register File

This block is the register storage and slot sequencer of a fine-grained barrel processor. It keeps a separate set of general registers for each hardware thread. A round-robin counter picks a new issuing thread on every clock. The front end presents two source register indices for the thread that is issuing. One registered clock later, the block returns both operand values together with the id of the thread they belong to.

Results come back from the last pipeline stage through a single write port. That port carries its own thread id, register index, data and enable. The execution pipeline is exactly as deep as the thread count. As a result, a thread's previous result is already committed to storage before the same thread reads operands again. No bypass or forwarding multiplexers exist anywhere in the block.

Storage is built as one copy of the file per read port. Every copy takes the same write, and each copy has one synchronous read, which suits block RAM inference.

Top module: `brf_top`

## Requirements
- R1: While `rst` is high at a rising edge, `issue_tid` becomes 0 and `opnd_tid` becomes THREADS-1 (3 by default).
- R2: With `rst` low, `issue_tid` advances by one at every rising edge and wraps from THREADS-1 to 0.
- R3: Operand values and `opnd_tid` are registered. After an edge, `opnd_tid` holds the `issue_tid` of the cycle before that edge. `opnd_a` and `opnd_b` hold the contents of that thread's registers `rd_idx_a` and `rd_idx_b` as presented in that cycle.
- R4: An entry is selected by the address {thread id, register index}, with the thread id in the upper bits. A write to one thread leaves the same register index of every other thread unchanged.
- R5: With `wb_en` low, storage is not modified, whatever values are on `wb_tid`, `wb_idx` and `wb_data`.
- R6: A read and a write of the same entry at the same edge return the data held before the write.
- R7: A result written back three cycles after its thread issued is returned by that thread's next read of the register. This holds with no forwarding path present.
- R8: The two read ports are independent. When both ports name the same register, both return that register's value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 5 | Source register index, port A, for the issuing thread |
| rd_idx_b | input | 5 | Source register index, port B, for the issuing thread |
| wb_en | input | 1 | Writeback enable |
| wb_tid | input | 2 | Thread owning the writeback |
| wb_idx | input | 5 | Destination register index of the writeback |
| wb_data | input | 32 | Writeback value |
| issue_tid | output | 2 | Thread issuing in the current cycle |
| opnd_tid | output | 2 | Thread whose operands are on `opnd_a` and `opnd_b` |
| opnd_a | output | 32 | Operand read through port A |
| opnd_b | output | 32 | Operand read through port B |

## Verification
The hardest case to reach is a true read-after-write dependency that crosses exactly one rotation. Here a thread's result lands in the cycle just before that same thread reads it again. That case only arises when writebacks are delayed by the true pipeline depth. The bench therefore models a three-stage result pipe behind the read port. Each issued instruction's destination becomes the next source of the same thread, so every such read depends on the last writeback. A directed phase also writes the entry being read at the same edge, to expose the old-data rule.

// File: rtl/brf_pkg.sv
package brf_pkg;
  localparam int DEF_THREADS = 4;
  localparam int DEF_REGS    = 32;
  localparam int DEF_WIDTH   = 32;
  localparam int READ_PORTS  = 2;
endpackage

// File: rtl/brf_slot_ctr.sv
module brf_slot_ctr #(
  parameter int THREADS = brf_pkg::DEF_THREADS
) (
  input  logic                       clk,
  input  logic                       rst,
  output logic [$clog2(THREADS)-1:0] slot
);
  localparam int TW = $clog2(THREADS);
  localparam logic [TW-1:0] LAST = TW'(THREADS - 1);

  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else if (slot == LAST) slot <= '0;
    else slot <= slot + TW'(1);
  end

  // R1: reset forces slot zero
  p_reset_slot_r1: assert property (@(posedge clk) rst |=> slot == '0);
  // R2: the slot never stays put and never leaves the legal range
  p_slot_moves_r2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (slot != $past(slot)) && (slot <= LAST));
endmodule

// File: rtl/brf_bank.sv
module brf_bank #(
  parameter int DEPTH = 128,
  parameter int WIDTH = brf_pkg::DEF_WIDTH
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [WIDTH-1:0]         wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [WIDTH-1:0]         rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // single write, single synchronous read: old data on collision
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

  // R5: an enabled write must carry a defined address
  p_waddr_known_r5: assert property (@(posedge clk) we |-> !$isunknown(waddr));
endmodule

// File: rtl/brf_top.sv
module brf_top #(
  parameter int THREADS = brf_pkg::DEF_THREADS,
  parameter int REGS    = brf_pkg::DEF_REGS,
  parameter int WIDTH   = brf_pkg::DEF_WIDTH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [$clog2(REGS)-1:0]    rd_idx_a,
  input  logic [$clog2(REGS)-1:0]    rd_idx_b,
  input  logic                       wb_en,
  input  logic [$clog2(THREADS)-1:0] wb_tid,
  input  logic [$clog2(REGS)-1:0]    wb_idx,
  input  logic [WIDTH-1:0]           wb_data,
  output logic [$clog2(THREADS)-1:0] issue_tid,
  output logic [$clog2(THREADS)-1:0] opnd_tid,
  output logic [WIDTH-1:0]           opnd_a,
  output logic [WIDTH-1:0]           opnd_b
);
  localparam int TW    = $clog2(THREADS);
  localparam int RW    = $clog2(REGS);
  localparam int AW    = TW + RW;
  localparam int DEPTH = THREADS * REGS;
  localparam int NRP   = brf_pkg::READ_PORTS;
  localparam logic [TW-1:0] LAST = TW'(THREADS - 1);

  logic [RW-1:0]    rd_idx [NRP];
  logic [WIDTH-1:0] rd_val [NRP];
  logic [AW-1:0]    wr_addr;

  assign rd_idx[0] = rd_idx_a;
  assign rd_idx[1] = rd_idx_b;
  assign wr_addr   = {wb_tid, wb_idx};

  brf_slot_ctr #(.THREADS(THREADS)) u_slot (
    .clk  (clk),
    .rst  (rst),
    .slot (issue_tid)
  );

  // one replica of the file per read port, all sharing the write
  for (genvar p = 0; p < NRP; p++) begin : g_port
    brf_bank #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_bank (
      .clk   (clk),
      .we    (wb_en),
      .waddr (wr_addr),
      .wdata (wb_data),
      .raddr ({issue_tid, rd_idx[p]}),
      .rdata (rd_val[p])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) opnd_tid <= LAST;
    else     opnd_tid <= issue_tid;
  end

  assign opnd_a = rd_val[0];
  assign opnd_b = rd_val[1];

  // R3: operand owner trails the issuing slot by exactly one position
  p_opnd_lag_r3: assert property (@(posedge clk) disable iff (rst)
    issue_tid == ((opnd_tid == LAST) ? '0 : opnd_tid + TW'(1)));
  // R1: reset places the operand owner on the last thread
  p_opnd_reset_r1: assert property (@(posedge clk) rst |=> opnd_tid == LAST);
endmodule

// File: tb/brf_top_test.sv
module brf_top_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_idx_a = '0, rd_idx_b = '0;
  logic        wb_en = 1'b0;
  logic [1:0]  wb_tid = '0;
  logic [4:0]  wb_idx = '0;
  logic [31:0] wb_data = '0;
  logic [1:0]  issue_tid, opnd_tid;
  logic [31:0] opnd_a, opnd_b;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;
  bit mon_on = 1'b0;
  logic [1:0] prev_tid;

  typedef struct packed {
    logic        chk;
    logic [3:0]  req;
    logic [1:0]  tid;
    logic [31:0] a;
    logic [31:0] b;
  } item_t;
  item_t sb_q[$];
  logic [31:0] model [4][32];

  brf_top uut (
    .clk(clk), .rst(rst), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b),
    .wb_en(wb_en), .wb_tid(wb_tid), .wb_idx(wb_idx), .wb_data(wb_data),
    .issue_tid(issue_tid), .opnd_tid(opnd_tid), .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  always #4 clk = ~clk;

  // driver half: call right after a falling edge
  task automatic apply(input logic [4:0] sa, input logic [4:0] sb,
                       input logic we, input logic [1:0] wt, input logic [4:0] wi,
                       input logic [31:0] wd, input logic chk, input logic [3:0] req);
    item_t it;
    rd_idx_a = sa; rd_idx_b = sb;
    wb_en = we; wb_tid = wt; wb_idx = wi; wb_data = wd;
    it.chk = chk; it.req = req; it.tid = issue_tid;
    it.a = model[issue_tid][sa];
    it.b = model[issue_tid][sb];
    sb_q.push_back(it);
    if (we) model[wt][wi] = wd;   // after sampling: same-edge read sees old data (R6)
  endtask

  task automatic step(input logic [4:0] sa, input logic [4:0] sb,
                      input logic we, input logic [1:0] wt, input logic [4:0] wi,
                      input logic [31:0] wd, input logic chk, input logic [3:0] req);
    @(negedge clk);
    apply(sa, sb, we, wt, wi, wd, chk, req);
  endtask

  // monitor: pops one expectation per cycle, after outputs settle
  always begin
    @(posedge clk);
    #2;
    if (mon_on) begin
      n_chk++;  // R2 rotation
      if (issue_tid !== prev_tid + 2'd1) begin
        n_bad++;
        $display("FAIL R2 issue_tid=%0d expected=%0d", issue_tid, prev_tid + 2'd1);
      end
      prev_tid = issue_tid;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        if (it.chk) begin
          n_chk++;  // R3 operand owner
          if (opnd_tid !== it.tid) begin
            n_bad++;
            $display("FAIL R3 opnd_tid=%0d expected=%0d", opnd_tid, it.tid);
          end
          n_chk++;
          if (opnd_a !== it.a) begin
            n_bad++;
            $display("FAIL R%0d port A actual=%h expected=%h", it.req, opnd_a, it.a);
          end
          n_chk++;
          if (opnd_b !== it.b) begin
            n_bad++;
            $display("FAIL R%0d port B actual=%h expected=%h", it.req, opnd_b, it.b);
          end
        end
      end
    end
  end

  initial begin
    logic        pv [3];
    logic [1:0]  pt [3];
    logic [4:0]  pd [3];
    logic [31:0] pval [3];
    logic [4:0]  last_dst [4];
    void'($urandom(7));
    repeat (3) @(posedge clk);
    @(negedge clk);
    n_chk++;  // R1 reset slot
    if (issue_tid !== 2'd0) begin
      n_bad++; $display("FAIL R1 issue_tid=%0d expected=0", issue_tid);
    end
    n_chk++;  // R1 reset operand owner
    if (opnd_tid !== 2'd3) begin
      n_bad++; $display("FAIL R1 opnd_tid=%0d expected=3", opnd_tid);
    end
    rst = 1'b0;
    prev_tid = issue_tid;
    mon_on = 1'b1;
    apply(5'd0, 5'd0, 1'b0, 2'd0, 5'd0, 32'd0, 1'b0, 4'd1);

    // fill all 128 entries, value tagged by {thread, register} (R4)
    for (int k = 0; k < 128; k++)
      step(5'd0, 5'd1, 1'b1, 2'(k / 32), 5'(k % 32),
           32'hC0DE0000 ^ (32'(k) * 32'h01030507), 1'b0, 4'd4);

    // same index on both ports, then distinct indices: R8 and R4
    for (int i = 0; i < 32; i++)
      step(5'(i), 5'(i), 1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 4'd8);
    for (int i = 0; i < 32; i++)
      step(5'(i), 5'(31 - i), 1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 4'd4);

    // disabled writes carrying live data must change nothing: R5
    for (int i = 0; i < 16; i++)
      step(5'(i), 5'(i), 1'b0, 2'(i), 5'(i), 32'hDEADBEEF, 1'b1, 4'd5);
    for (int i = 0; i < 16; i++)
      step(5'(i), 5'(i + 16), 1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 4'd5);

    // same-edge read and write of one entry returns the old value: R6
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      apply(5'(i + 3), 5'(i + 3), 1'b1, issue_tid, 5'(i + 3),
            32'h6600_0000 + 32'(i), 1'b1, 4'd6);
    end
    for (int i = 0; i < 12; i++)   // read back the new values
      step(5'((i / 4) * 4 + 3), 5'(i + 3), 1'b0, 2'd0, 5'd0, 32'd0, 1'b1, 4'd6);

    // modelled 4-deep pipeline with chained dependencies: R7
    for (int s = 0; s < 3; s++) pv[s] = 1'b0;
    for (int t = 0; t < 4; t++) last_dst[t] = 5'(t);
    for (int c = 0; c < 400; c++) begin
      logic [1:0]  tid;
      logic [4:0]  sa, sb, dst;
      logic [31:0] res;
      @(negedge clk);
      tid = issue_tid;
      sa  = last_dst[tid];
      sb  = 5'($urandom_range(0, 31));
      dst = (c < 392) ? 5'($urandom_range(0, 31)) : sa;
      res = model[tid][sa] + model[tid][sb] + 32'(c) + 32'd1;
      apply(sa, sb, pv[2], pt[2], pd[2], pval[2], 1'b1, 4'd7);
      pv[2] = pv[1]; pt[2] = pt[1]; pd[2] = pd[1]; pval[2] = pval[1];
      pv[1] = pv[0]; pt[1] = pt[0]; pd[1] = pd[0]; pval[1] = pval[0];
      pv[0] = 1'b1;  pt[0] = tid;   pd[0] = dst;   pval[0] = res;
      last_dst[tid] = dst;
    end
    for (int c = 0; c < 8; c++) begin   // drain the pipe, keep reading
      @(negedge clk);
      apply(last_dst[issue_tid], 5'(c), pv[2], pt[2], pd[2], pval[2], 1'b1, 4'd7);
      pv[2] = pv[1]; pt[2] = pt[1]; pd[2] = pd[1]; pval[2] = pval[1];
      pv[1] = pv[0]; pt[1] = pt[0]; pd[1] = pd[0]; pval[1] = pval[0];
      pv[0] = 1'b0;
    end

    // unconstrained mix of reads and writes: R3
    for (int c = 0; c < 300; c++)
      step(5'($urandom_range(0, 31)), 5'($urandom_range(0, 31)),
           1'($urandom_range(0, 1)), 2'($urandom_range(0, 3)),
           5'($urandom_range(0, 31)), $urandom, 1'b1, 4'd3);

    step(5'd0, 5'd0, 1'b0, 2'd0, 5'd0, 32'd0, 1'b0, 4'd3);
    @(posedge clk);
    #3;
    mon_on = 1'b0;
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule